// File: doc/BRIEF.md
# PWM Buffered-Register Synchronization Controller

This block decides when the write buffers of a PWM timer's double-buffered registers are copied into the active registers that drive the waveform logic. Software writes go only to the buffers. A synchronization event copies every buffered setting into its active copy in one clock edge and restarts the timer counter at its initial count. The settings are the period limit, the initial count, one compare value per channel, the channel output mask, the per-channel inversion and the software output override.

Three hardware trigger inputs can start an event. Each trigger is asynchronous. It is brought into the clock domain by a two-flop synchronizer, and its rising edge is found by comparing it with its registered previous value. A trigger counts only while its own enable bit is set. In clearing mode an enable bit drops by itself once its trigger has fired, so one enable arms exactly one event. In holding mode the enable bits change only by register write. Compare values have two load policies. They can follow their buffer at the next prescaler tick, or they can wait for a synchronization event. The block also contains the timer counter, which advances on the prescaler tick.

Top module: `pwm_bufsync_ctrl`

## Requirements
- R1: After reset, all trigger enables, all buffered and active registers, the counter and `sync_pulse` are 0.
- R2: A register write changes only the write buffer. The period limit, initial count, mask, inversion and override outputs keep their value until a synchronization event occurs. Address map: 0 control, 1 period limit, 2 initial count, 3 mask, 4 inversion, 5 override, 8+n compare of channel n. Control bits: [2:0] trigger enables, [4] trigger mode (1 = holding), [5] compare waits for synchronization.
- R3: A rising edge on trigger input i while enable i is 1 gives `sync_pulse` high for exactly one cycle. The pulse appears after the third rising clock edge following the input rise. At that same edge every active register takes its buffered value. A trigger held high does not cause a second event, and a trigger whose enable is 0 causes none.
- R4: At a synchronization event the counter is loaded with the buffered initial count.
- R5: In clearing mode (mode bit 0), the event on trigger i clears enable i and leaves the other enables unchanged.
- R6: A control write that sets enable i in the same cycle that trigger i's event is taken still starts synchronization, and enable i stays 1.
- R7: Enabled triggers that rise in the same cycle give a single one-cycle pulse. In clearing mode all of their enables are cleared.
- R8: In holding mode (mode bit 1), trigger events leave the enables unchanged.
- R9: With control bit 5 at 0, a written compare value becomes active at the next prescaler tick.
- R10: With control bit 5 at 1, a compare value does not change at prescaler ticks and becomes active only at a synchronization event.
- R11: On each prescaler tick the counter adds 1. When it equals or exceeds the active period limit, it reloads the active initial count instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Write data |
| trig_in | input | NUM_TRIG | Asynchronous hardware trigger inputs |
| presc_tick | input | 1 | End-of-prescaler-count pulse |
| count | output | CNT_W | Timer counter value |
| sync_pulse | output | 1 | One-cycle synchronization event marker |
| trig_en | output | NUM_TRIG | Current trigger enable bits |
| mod_act | output | CNT_W | Active period limit |
| cntin_act | output | CNT_W | Active initial count |
| cv_act | output | NUM_CH*CNT_W | Active compare values, channel 0 in the low bits |
| omask_act | output | NUM_CH | Active output mask |
| inv_act | output | NUM_CH | Active inversion control |
| swo_act | output | 2*NUM_CH | Active software output override |

## Verification
The main sweep pairs every one of the eight enable patterns with each of the three trigger inputs, once in clearing mode and once in holding mode. Across that sweep it separates three cases: a trigger that should load, a disabled trigger that must not load, and an enable that should clear from one that must stay set. New buffer values are written before each trigger, so a missed or spurious load shows as a stale or early active value. Separate patterns cover two triggers rising together, a control write that coincides with the detected edge, both compare-load policies under prescaler ticks, and counter wrap against a synchronized period limit.

// File: rtl/pwm_sync_pkg.sv
// Shared address map and control-bit positions of the PWM buffer
// synchronization controller. Assumes at most 8 compare channels.
package pwm_sync_pkg;
    localparam int ADDR_W          = 4;
    localparam int CTRL_MODE_BIT   = 4;
    localparam int CTRL_CVSYNC_BIT = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_MOD   = 4'd1,
        A_CNTIN = 4'd2,
        A_OMASK = 4'd3,
        A_INV   = 4'd4,
        A_SWO   = 4'd5,
        A_CV0   = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/pwm_trig_detect.sv
// Brings each asynchronous trigger into the clock domain with two flops,
// then flags a rising edge by comparing with the registered previous value.
// Assumes triggers stay high or low for at least one clock.
module pwm_trig_detect #(
    parameter int NUM_TRIG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_raw,
    output logic [NUM_TRIG-1:0] trig_rise
);
    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
        logic meta_q, sync_q, prev_q;

        // Two-flop synchronizer plus previous-value register for one trigger.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= trig_raw[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign trig_rise[g] = sync_q & ~prev_q;
    end
endmodule

// File: rtl/pwm_trig_enable.sv
// Holds the trigger enable bits and decides when a synchronization event
// fires. A control write always sets the next enable value. Otherwise, in
// clearing mode, a fired trigger drops its own enable bit.
module pwm_trig_enable #(
    parameter int NUM_TRIG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [NUM_TRIG-1:0] ctrl_bits,
    input  logic                hold_mode,
    input  logic [NUM_TRIG-1:0] trig_rise,
    output logic [NUM_TRIG-1:0] trig_en,
    output logic [NUM_TRIG-1:0] fire_vec,
    output logic                fire,
    output logic                sync_pulse
);
    logic [NUM_TRIG-1:0] en_q;
    logic [NUM_TRIG-1:0] en_d;

    assign fire_vec = trig_rise & en_q;
    assign fire     = |fire_vec;
    assign trig_en  = en_q;

    // Next enable value: the write wins, then self-clear in clearing mode.
    always_comb begin
        en_d = en_q;
        if (ctrl_wr) begin
            en_d = ctrl_bits;
        end else if (!hold_mode) begin
            en_d = en_q & ~fire_vec;
        end
    end

    // Enable register and registered event marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            sync_pulse <= 1'b0;
        end else begin
            en_q       <= en_d;
            sync_pulse <= fire;
        end
    end
endmodule

// File: rtl/pwm_shadow_regs.sv
// Write buffers and active copies of the timer settings, plus the control
// flags. Every active register loads at a synchronization event. Compare
// values may also load at a prescaler tick when configured that way.
module pwm_shadow_regs
    import pwm_sync_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_CH   = 2,
    parameter int NUM_TRIG = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic                    load_all,
    input  logic                    presc_tick,
    output logic                    ctrl_wr,
    output logic [NUM_TRIG-1:0]     ctrl_bits,
    output logic                    hold_mode,
    output logic                    cv_sync_en,
    output logic [CNT_W-1:0]        mod_buf,
    output logic [CNT_W-1:0]        cntin_buf,
    output logic [CNT_W-1:0]        mod_act,
    output logic [CNT_W-1:0]        cntin_act,
    output logic [NUM_CH*CNT_W-1:0] cv_act,
    output logic [NUM_CH-1:0]       omask_act,
    output logic [NUM_CH-1:0]       inv_act,
    output logic [2*NUM_CH-1:0]     swo_act
);
    localparam int SWO_W = 2 * NUM_CH;

    logic [NUM_CH-1:0] omask_buf, inv_buf;
    logic [SWO_W-1:0]  swo_buf;

    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign ctrl_bits = wr_data[NUM_TRIG-1:0];

    // Control flags: trigger mode and compare load policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_mode  <= 1'b0;
            cv_sync_en <= 1'b0;
        end else if (ctrl_wr) begin
            hold_mode  <= wr_data[CTRL_MODE_BIT];
            cv_sync_en <= wr_data[CTRL_CVSYNC_BIT];
        end
    end

    // Write buffers of the non-compare settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_buf   <= '0;
            cntin_buf <= '0;
            omask_buf <= '0;
            inv_buf   <= '0;
            swo_buf   <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MOD)   mod_buf   <= wr_data;
            if (wr_addr == A_CNTIN) cntin_buf <= wr_data;
            if (wr_addr == A_OMASK) omask_buf <= wr_data[NUM_CH-1:0];
            if (wr_addr == A_INV)   inv_buf   <= wr_data[NUM_CH-1:0];
            if (wr_addr == A_SWO)   swo_buf   <= wr_data[SWO_W-1:0];
        end
    end

    // Active copies, loaded only at a synchronization event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_act   <= '0;
            cntin_act <= '0;
            omask_act <= '0;
            inv_act   <= '0;
            swo_act   <= '0;
        end else if (load_all) begin
            mod_act   <= mod_buf;
            cntin_act <= cntin_buf;
            omask_act <= omask_buf;
            inv_act   <= inv_buf;
            swo_act   <= swo_buf;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cv
        logic             wr_cv;
        logic [CNT_W-1:0] cv_buf_q, cv_act_q;

        assign wr_cv = wr_en && wr_addr[3] && (wr_addr[2:0] == 3'(g));

        // Per-channel compare buffer and active value with its load policy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cv_buf_q <= '0;
                cv_act_q <= '0;
            end else begin
                if (wr_cv) cv_buf_q <= wr_data;
                if (load_all || (presc_tick && !cv_sync_en)) cv_act_q <= cv_buf_q;
            end
        end

        assign cv_act[g*CNT_W +: CNT_W] = cv_act_q;
    end
endmodule

// File: rtl/pwm_counter.sv
// Timer counter. It advances on the prescaler tick and wraps from the
// period limit to the initial count. A synchronization event forces it to
// the buffered initial count and takes priority over the tick.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_load,
    input  logic [CNT_W-1:0] force_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] start,
    output logic [CNT_W-1:0] count
);
    // Counter register with forced load, wrap and increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (force_load) begin
            count <= force_val;
        end else if (tick) begin
            if (count >= limit) count <= start;
            else                count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_bufsync_ctrl.sv
// Top of the PWM buffer synchronization controller: trigger edge detection,
// enable handling, buffered settings and the timer counter. Assumes
// NUM_CH <= 8, 2*NUM_CH <= CNT_W and NUM_TRIG <= 4.
module pwm_bufsync_ctrl
    import pwm_sync_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_CH   = 2,
    parameter int NUM_TRIG = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic [NUM_TRIG-1:0]     trig_in,
    input  logic                    presc_tick,
    output logic [CNT_W-1:0]        count,
    output logic                    sync_pulse,
    output logic [NUM_TRIG-1:0]     trig_en,
    output logic [CNT_W-1:0]        mod_act,
    output logic [CNT_W-1:0]        cntin_act,
    output logic [NUM_CH*CNT_W-1:0] cv_act,
    output logic [NUM_CH-1:0]       omask_act,
    output logic [NUM_CH-1:0]       inv_act,
    output logic [2*NUM_CH-1:0]     swo_act
);
    logic [NUM_TRIG-1:0] trig_rise_w, fire_vec_w, ctrl_bits_w;
    logic                fire_w, ctrl_wr_w, hold_mode_w, cv_sync_w;
    logic [CNT_W-1:0]    mod_buf_w, cntin_buf_w;

    pwm_trig_detect #(.NUM_TRIG(NUM_TRIG)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_raw  (trig_in),
        .trig_rise (trig_rise_w)
    );

    pwm_trig_enable #(.NUM_TRIG(NUM_TRIG)) u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr_w),
        .ctrl_bits  (ctrl_bits_w),
        .hold_mode  (hold_mode_w),
        .trig_rise  (trig_rise_w),
        .trig_en    (trig_en),
        .fire_vec   (fire_vec_w),
        .fire       (fire_w),
        .sync_pulse (sync_pulse)
    );

    pwm_shadow_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load_all   (fire_w),
        .presc_tick (presc_tick),
        .ctrl_wr    (ctrl_wr_w),
        .ctrl_bits  (ctrl_bits_w),
        .hold_mode  (hold_mode_w),
        .cv_sync_en (cv_sync_w),
        .mod_buf    (mod_buf_w),
        .cntin_buf  (cntin_buf_w),
        .mod_act    (mod_act),
        .cntin_act  (cntin_act),
        .cv_act     (cv_act),
        .omask_act  (omask_act),
        .inv_act    (inv_act),
        .swo_act    (swo_act)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_load (fire_w),
        .force_val  (cntin_buf_w),
        .tick       (presc_tick),
        .limit      (mod_act),
        .start      (cntin_act),
        .count      (count)
    );
endmodule

// File: rtl/pwm_bufsync_chk.sv
// Property checker for pwm_bufsync_ctrl, attached by the bind below.
module pwm_bufsync_chk #(
    parameter int CNT_W    = 16,
    parameter int NUM_CH   = 2,
    parameter int NUM_TRIG = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sync_pulse,
    input logic [CNT_W-1:0]        count,
    input logic [CNT_W-1:0]        cntin_act,
    input logic [CNT_W-1:0]        mod_act,
    input logic [CNT_W-1:0]        mod_buf,
    input logic [NUM_TRIG-1:0]     fire_vec,
    input logic [NUM_TRIG-1:0]     trig_en,
    input logic                    ctrl_wr,
    input logic                    hold_mode,
    input logic                    cv_sync_en,
    input logic [NUM_CH*CNT_W-1:0] cv_act
);
    // R3: the event marker comes with the active period limit taken from its buffer.
    assert_mod_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (mod_act == $past(mod_buf)));

    // R4: at the event the counter equals the new initial count.
    assert_count_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (count == cntin_act));

    // R5: in clearing mode a fired trigger's enable is gone unless a write intervened.
    assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl_wr) && !$past(hold_mode)) |-> ((trig_en & $past(fire_vec)) == '0));

    // R8: in holding mode the enables move only by write.
    assert_hold_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold_mode) && !$past(ctrl_wr)) |-> $stable(trig_en));

    // R10: with compare-sync set, compares change only at an event.
    assert_cv_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cv_sync_en) && !sync_pulse) |-> $stable(cv_act));
endmodule

bind pwm_bufsync_ctrl pwm_bufsync_chk #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pulse (sync_pulse),
    .count      (count),
    .cntin_act  (cntin_act),
    .mod_act    (mod_act),
    .mod_buf    (mod_buf_w),
    .fire_vec   (fire_vec_w),
    .trig_en    (trig_en),
    .ctrl_wr    (ctrl_wr_w),
    .hold_mode  (hold_mode_w),
    .cv_sync_en (cv_sync_w),
    .cv_act     (cv_act)
);

// File: tb/sim_pwm_bufsync_ctrl.sv
// Bench: sweeps enable patterns x trigger inputs x modes, then corner cases.
module sim_pwm_bufsync_ctrl;
    localparam int CNT_W = 16, NUM_CH = 2, NUM_TRIG = 3;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, presc_tick = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [NUM_TRIG-1:0] trig_in = '0;
    logic [CNT_W-1:0] count, mod_act, cntin_act;
    logic sync_pulse;
    logic [NUM_TRIG-1:0] trig_en;
    logic [NUM_CH*CNT_W-1:0] cv_act;
    logic [NUM_CH-1:0] omask_act, inv_act;
    logic [2*NUM_CH-1:0] swo_act;

    int total = 0, bad = 0;
    logic [CNT_W-1:0] e_mod, e_cntin, e_cv0, e_cv1;
    logic [1:0] e_om, e_inv;
    logic [3:0] e_swo;

    always #2 clk = ~clk;

    pwm_bufsync_ctrl #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_in(trig_in), .presc_tick(presc_tick), .count(count), .sync_pulse(sync_pulse),
        .trig_en(trig_en), .mod_act(mod_act), .cntin_act(cntin_act), .cv_act(cv_act),
        .omask_act(omask_act), .inv_act(inv_act), .swo_act(swo_act)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Raise a trigger pattern; optionally write control in the edge cycle.
    // Returns at the negedge after the third posedge following the rise.
    task automatic fire(input logic [2:0] pat, input logic co_wr, input logic [CNT_W-1:0] co_d);
        @(negedge clk); trig_in = pat;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        if (co_wr) begin wr_en = 1'b1; wr_addr = 4'd0; wr_data = co_d; end
        @(posedge clk);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic release_trig();
        trig_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); presc_tick = 1'b1;
        @(negedge clk); presc_tick = 1'b0;
    endtask

    task automatic chk_act(input string tag);
        chk({tag, " mod"}, 64'(mod_act), 64'(e_mod));
        chk({tag, " cntin"}, 64'(cntin_act), 64'(e_cntin));
        chk({tag, " mask"}, 64'(omask_act), 64'(e_om));
        chk({tag, " inv"}, 64'(inv_act), 64'(e_inv));
        chk({tag, " swo"}, 64'(swo_act), 64'(e_swo));
        chk({tag, " cv"}, 64'(cv_act), {32'd0, e_cv1, e_cv0});
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        e_mod = 0; e_cntin = 0; e_cv0 = 0; e_cv1 = 0; e_om = 0; e_inv = 0; e_swo = 0;
        // R1 reset state
        chk("R1 sync", 64'(sync_pulse), 0);
        chk("R1 en", 64'(trig_en), 0);
        chk("R1 count", 64'(count), 0);
        chk_act("R1");

        // Sweep: mode x enable pattern x trigger input (compare waits for sync).
        for (int m = 0; m < 2; m++) begin
            for (int mask = 0; mask < 8; mask++) begin
                for (int t = 0; t < 3; t++) begin
                    int k;
                    logic hit;
                    logic [2:0] e_en;
                    k = m * 24 + mask * 3 + t;
                    wr(4'd1, CNT_W'(100 + k));
                    wr(4'd2, CNT_W'(k));
                    wr(4'd3, CNT_W'(k & 3));
                    wr(4'd4, CNT_W'((k + 1) & 3));
                    wr(4'd5, CNT_W'(k & 15));
                    wr(4'd8, CNT_W'(200 + k));
                    wr(4'd9, CNT_W'(300 + k));
                    wr(4'd0, CNT_W'(mask | (m << 4) | (1 << 5)));
                    chk("R2 en written", 64'(trig_en), 64'(mask));
                    chk_act("R2 buffered only");
                    fire(3'(1 << t), 1'b0, '0);
                    hit = mask[t];
                    chk("R3 pulse", 64'(sync_pulse), 64'(hit));
                    if (hit) begin
                        e_mod = CNT_W'(100 + k); e_cntin = CNT_W'(k);
                        e_om = 2'(k & 3); e_inv = 2'((k + 1) & 3); e_swo = 4'(k & 15);
                        e_cv0 = CNT_W'(200 + k); e_cv1 = CNT_W'(300 + k);
                        chk("R4 count", 64'(count), 64'(k));
                    end
                    chk_act("R3 load");
                    e_en = (m == 0 && hit) ? 3'(mask & ~(1 << t)) : 3'(mask);
                    chk(m == 0 ? "R5 clear" : "R8 hold", 64'(trig_en), 64'(e_en));
                    @(negedge clk);
                    chk("R3 single pulse", 64'(sync_pulse), 0);
                    release_trig();
                end
            end
        end

        // R7: two enabled triggers rising together.
        wr(4'd1, 16'd77);
        wr(4'd0, 16'h0027);
        fire(3'b101, 1'b0, '0);
        e_mod = 16'd77;
        chk("R7 pulse", 64'(sync_pulse), 1);
        chk("R7 both cleared", 64'(trig_en), 64'b010);
        chk("R7 mod", 64'(mod_act), 64'(e_mod));
        @(negedge clk);
        chk("R7 single", 64'(sync_pulse), 0);
        release_trig();

        // R6: write setting the enable in the edge cycle.
        wr(4'd1, 16'd88);
        wr(4'd0, 16'h0021);
        fire(3'b001, 1'b1, 16'h0021);
        e_mod = 16'd88;
        chk("R6 pulse", 64'(sync_pulse), 1);
        chk("R6 en kept", 64'(trig_en), 64'b001);
        chk("R6 mod", 64'(mod_act), 64'(e_mod));
        release_trig();

        // R9: immediate compare policy loads at the tick.
        wr(4'd0, 16'h0000);
        wr(4'd8, 16'd555);
        chk("R9 before tick", 64'(cv_act[15:0]), 64'(e_cv0));
        tick();
        chk("R9 after tick", 64'(cv_act[15:0]), 555);

        // R10: sync compare policy ignores ticks.
        wr(4'd0, 16'h0031);
        wr(4'd8, 16'd777);
        tick();
        chk("R10 tick ignored", 64'(cv_act[15:0]), 555);

        // Sync loads compare, mod=3 and cntin=1 for the counter test.
        wr(4'd1, 16'd3);
        wr(4'd2, 16'd1);
        fire(3'b001, 1'b0, '0);
        chk("R10 sync load", 64'(cv_act[15:0]), 777);
        chk("R4 count", 64'(count), 1);
        release_trig();

        // R11: counting and wrap.
        tick(); chk("R11 step", 64'(count), 2);
        tick(); chk("R11 step", 64'(count), 3);
        tick(); chk("R11 wrap", 64'(count), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule